// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer

This block times one DRAM read or write access. A 16-bit timing word sets five delays in memory clocks: row address setup, the time the row address stays on the bus after the row strobe rises, column address setup, the column strobe width and the row strobe hold time after the column strobe falls. When a request is accepted, the block drives the row address and raises the row strobe. It then switches the multiplexed address to the column and pulses the column strobe. On writes it raises write-enable ahead of the column strobe. Last, it drops the row strobe and signals completion.

The timing word and both addresses are captured at the moment a request is accepted. A word with a zero field, or with a column-output count smaller than the row-setup count, is refused with an error pulse. Refresh, page-mode bursts and the data path belong to other blocks.

Top module: `dram_strobe_seq`

## Requirements
- R1: The timing word is decoded as follows: row setup A = bits 1:0, column setup S = bits 3:2, column address output C = bits 5:4, row hold H = bits 8:6, column strobe width W = bits 15:11. A field value N means N clocks. Bits 10:9 have no effect.
- R2: A request sampled while idle with any zero field, or with C < A, gives config_error high for exactly the next cycle. No access is started: busy and row_strobe stay low.
- R3: Cycle 0 is the first clock after the accepting edge, and T = A+C+S+W+H. row_strobe is high in cycles A to T-1 and low at all other times.
- R4: addr_sel_col is high in cycles C+A to T-1. addr_out shows the captured column address while addr_sel_col is high, and the captured row address at all other times.
- R5: col_strobe is high in cycles A+C+S to A+C+S+W-1.
- R6: After col_strobe falls, row_strobe stays high for exactly H more cycles.
- R7: On a write (req_write high at acceptance), wr_en is high in cycles A+C to A+C+S+W-1 and falls together with col_strobe. On a read it stays low.
- R8: done is high only in cycle T, the first cycle with row_strobe low. busy is high in cycles 0 to T. A request sampled while busy is high is ignored, so a request held high starts its next access with cycle 0 at T+2.
- R9: The timing word, the addresses and req_write are captured at acceptance. Changing them during an access does not alter that access.
- R10: While rst_n is low, all outputs are low and the sequencer is idle. This applies even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Timing word |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| row_addr | input | ADDR_W | Row address |
| col_addr | input | ADDR_W | Column address |
| addr_out | output | ADDR_W | Multiplexed address to the DRAM |
| addr_sel_col | output | 1 | 1 = addr_out carries the column address |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| wr_en | output | 1 | Write enable, active high |
| done | output | 1 | One-cycle pulse when the row strobe is released |
| busy | output | 1 | Access in progress |
| config_error | output | 1 | One-cycle pulse when an illegal timing word is refused |

## Verification
A new request can coincide with the done cycle, and that request must not be taken before the sequencer is idle again. The bench holds req high through a complete access. It checks that done appears in cycle T while the request is still pending, that busy drops for exactly one cycle, and that the second access begins at T+2. It also pulses a request with an illegal word during an access, and checks that the running sequence goes on unchanged and that no error is reported.

// File: rtl/dss_pkg.sv
package dss_pkg;

   localparam int CFG_W      = 16;
   localparam int ASR_LSB    = 0;
   localparam int ASC_LSB    = 2;
   localparam int CAO_LSB    = 4;
   localparam int RSH_LSB    = 6;
   localparam int CASW_LSB   = 11;
   localparam int SHORT_W    = 2;
   localparam int RSH_W      = 3;
   localparam int CASW_W     = 5;
   localparam int CNT_W      = CASW_W;

   typedef struct packed {
      logic [CASW_W-1:0]  casw;
      logic [RSH_W-1:0]   rsh;
      logic [SHORT_W-1:0] cao;
      logic [SHORT_W-1:0] asc;
      logic [SHORT_W-1:0] asr;
   } dram_timing_t;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RSETUP = 3'd1,
      ST_ROWHLD = 3'd2,
      ST_CSETUP = 3'd3,
      ST_CAS    = 3'd4,
      ST_RHOLD  = 3'd5,
      ST_FINISH = 3'd6
   } seq_state_e;

endpackage

// File: rtl/dss_cfg_decode.sv
module dss_cfg_decode
   import dss_pkg::*;
#(
   parameter bit ENFORCE_ORDER = 1'b1
) (
   input  logic [CFG_W-1:0] cfg_word,
   output dram_timing_t     timing,
   output logic             legal
);

   logic fields_nonzero;
   logic order_ok;
   logic unused_spare;

   assign timing.asr  = cfg_word[ASR_LSB  +: SHORT_W];
   assign timing.asc  = cfg_word[ASC_LSB  +: SHORT_W];
   assign timing.cao  = cfg_word[CAO_LSB  +: SHORT_W];
   assign timing.rsh  = cfg_word[RSH_LSB  +: RSH_W];
   assign timing.casw = cfg_word[CASW_LSB +: CASW_W];
   assign unused_spare = ^cfg_word[CASW_LSB-1:RSH_LSB+RSH_W];

   assign fields_nonzero = (timing.asr  != '0) && (timing.asc != '0) &&
                           (timing.cao  != '0) && (timing.rsh != '0) &&
                           (timing.casw != '0);

   generate
      if (ENFORCE_ORDER) begin : g_order
         assign order_ok = (timing.cao >= timing.asr);
      end else begin : g_no_order
         assign order_ok = 1'b1;
      end
   endgenerate

   assign legal = fields_nonzero && order_ok;

endmodule

// File: rtl/dss_phase_timer.sv
module dss_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 2) else $error("dss_phase_timer: CNT_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dss_addr_path.sv
module dss_addr_path #(
   parameter int ADDR_W     = 12,
   parameter bit LATCH_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              sel_col,
   input  logic [ADDR_W-1:0] row_in,
   input  logic [ADDR_W-1:0] col_in,
   output logic [ADDR_W-1:0] addr_out
);

   logic [ADDR_W-1:0] row_q;
   logic [ADDR_W-1:0] col_q;

   generate
      if (LATCH_ADDR) begin : g_latched
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= '0;
               col_q <= '0;
            end else if (capture) begin
               row_q <= row_in;
               col_q <= col_in;
            end
         end
      end else begin : g_passthru
         logic unused_cap;
         assign unused_cap = capture ^ clk ^ rst_n;
         assign row_q = row_in;
         assign col_q = col_in;
      end
   endgenerate

   assign addr_out = sel_col ? col_q : row_q;

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
   import dss_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter bit LATCH_ADDR    = 1'b1,
   parameter bit ENFORCE_ORDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cfg_word,
   input  logic              req,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] row_addr,
   input  logic [ADDR_W-1:0] col_addr,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_sel_col,
   output logic              row_strobe,
   output logic              col_strobe,
   output logic              wr_en,
   output logic              done,
   output logic              busy,
   output logic              config_error
);

   initial begin
      assert (ADDR_W >= 1) else $error("dram_strobe_seq: ADDR_W must be positive");
      assert (CFG_W == 16) else $error("dram_strobe_seq: timing word must be 16 bits");
   end

   seq_state_e   state_q, state_d;
   dram_timing_t live_tm, tm_q;
   logic         cfg_legal;
   logic         accept;
   logic         step;
   logic         phase_last;
   logic [CNT_W-1:0] load_val;
   logic         wr_q;
   logic         err_q;

   dss_cfg_decode #(.ENFORCE_ORDER(ENFORCE_ORDER)) i_decode (
      .cfg_word (cfg_word),
      .timing   (live_tm),
      .legal    (cfg_legal)
   );

   dss_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (step),
      .load_val (load_val),
      .last     (phase_last)
   );

   assign accept = (state_q == ST_IDLE) && req && cfg_legal;

   always_comb begin
      state_d  = state_q;
      step     = 1'b0;
      load_val = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               state_d  = ST_RSETUP;
               step     = 1'b1;
               load_val = CNT_W'(live_tm.asr);
            end
         end
         ST_RSETUP: begin
            if (phase_last) begin
               state_d  = ST_ROWHLD;
               step     = 1'b1;
               load_val = CNT_W'(tm_q.cao);
            end
         end
         ST_ROWHLD: begin
            if (phase_last) begin
               state_d  = ST_CSETUP;
               step     = 1'b1;
               load_val = CNT_W'(tm_q.asc);
            end
         end
         ST_CSETUP: begin
            if (phase_last) begin
               state_d  = ST_CAS;
               step     = 1'b1;
               load_val = CNT_W'(tm_q.casw);
            end
         end
         ST_CAS: begin
            if (phase_last) begin
               state_d  = ST_RHOLD;
               step     = 1'b1;
               load_val = CNT_W'(tm_q.rsh);
            end
         end
         ST_RHOLD: begin
            if (phase_last) begin
               state_d = ST_FINISH;
            end
         end
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tm_q    <= '0;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= (state_q == ST_IDLE) && req && !cfg_legal;
         if (accept) begin
            tm_q <= live_tm;
            wr_q <= req_write;
         end
      end
   end

   dss_addr_path #(.ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR)) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (accept),
      .sel_col  (addr_sel_col),
      .row_in   (row_addr),
      .col_in   (col_addr),
      .addr_out (addr_out)
   );

   assign row_strobe   = (state_q == ST_ROWHLD) || (state_q == ST_CSETUP) ||
                         (state_q == ST_CAS)    || (state_q == ST_RHOLD);
   assign addr_sel_col = (state_q == ST_CSETUP) || (state_q == ST_CAS) ||
                         (state_q == ST_RHOLD);
   assign col_strobe   = (state_q == ST_CAS);
   assign wr_en        = wr_q && ((state_q == ST_CSETUP) || (state_q == ST_CAS));
   assign done         = (state_q == ST_FINISH);
   assign busy         = (state_q != ST_IDLE);
   assign config_error = err_q;

endmodule

// File: rtl/dss_checker.sv
module dss_checker (
   input logic clk,
   input logic rst_n,
   input logic row_strobe,
   input logic col_strobe,
   input logic addr_sel_col,
   input logic wr_en,
   input logic done,
   input logic busy,
   input logic config_error
);

   assert_refused_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |-> (!busy && !row_strobe));

   assert_col_addr_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_sel_col) |-> $past(row_strobe));

   assert_cas_after_col_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col_strobe) |-> $past(addr_sel_col));

   assert_cas_inside_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      col_strobe |-> (row_strobe && addr_sel_col));

   assert_ras_held_past_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_strobe) |-> row_strobe);

   assert_we_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (row_strobe && addr_sel_col));

   assert_we_drops_with_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_strobe) |-> !wr_en);

   assert_done_on_ras_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!row_strobe && $past(row_strobe) && busy));

   assert_done_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, config_error}));

endmodule

bind dram_strobe_seq dss_checker i_dss_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .row_strobe   (row_strobe),
   .col_strobe   (col_strobe),
   .addr_sel_col (addr_sel_col),
   .wr_en        (wr_en),
   .done         (done),
   .busy         (busy),
   .config_error (config_error)
);

// File: tb/test_dram_strobe_seq.sv
module test_dram_strobe_seq;

   localparam int AW = 12;
   localparam logic [AW-1:0] RA = 12'h5A3;
   localparam logic [AW-1:0] CA = 12'h1C7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   cfg_word = '0;
   logic          req = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] row_addr = '0;
   logic [AW-1:0] col_addr = '0;
   logic [AW-1:0] addr_out;
   logic          addr_sel_col, row_strobe, col_strobe, wr_en, done, busy, config_error;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dram_strobe_seq #(.ADDR_W(AW)) i_dram_strobe_seq (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req(req), .req_write(req_write),
      .row_addr(row_addr), .col_addr(col_addr), .addr_out(addr_out),
      .addr_sel_col(addr_sel_col), .row_strobe(row_strobe), .col_strobe(col_strobe),
      .wr_en(wr_en), .done(done), .busy(busy), .config_error(config_error)
   );

   // {write, casw[4:0], spare[1:0], rsh[2:0], cao[1:0], asc[1:0], asr[1:0]}
   localparam logic [16:0] VECS [0:7] = '{
      {1'b0, 5'd1,  2'b00, 3'd1, 2'd1, 2'd1, 2'd1},
      {1'b1, 5'd1,  2'b00, 3'd1, 2'd1, 2'd1, 2'd1},
      {1'b1, 5'd31, 2'b00, 3'd7, 2'd3, 2'd3, 2'd3},
      {1'b0, 5'd31, 2'b00, 3'd7, 2'd3, 2'd3, 2'd3},
      {1'b1, 5'd5,  2'b11, 3'd2, 2'd3, 2'd1, 2'd2},
      {1'b0, 5'd7,  2'b10, 3'd4, 2'd2, 2'd3, 2'd2},
      {1'b1, 5'd2,  2'b01, 3'd3, 2'd2, 2'd2, 2'd1},
      {1'b0, 5'd12, 2'b00, 3'd6, 2'd3, 2'd2, 2'd3}
   };

   function automatic logic [15:0] mk(input int a, input int s, input int c, input int h, input int w);
      return {5'(w), 2'b00, 3'(h), 2'(c), 2'(s), 2'(a)};
   endfunction

   task automatic check1(input bit ok, input string req_tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
      end
   endtask

   task automatic cmp_cycle(input int t, input int a, input int c, input int s, input int w,
                            input int h, input bit wr, input string tag);
      int tt;
      logic e_ras, e_sel, e_cas, e_we, e_done, e_busy;
      logic [AW-1:0] e_addr;
      logic [AW+6:0] act, exp;
      tt = a + c + s + w + h;
      e_ras  = (t >= a) && (t < tt);
      e_sel  = (t >= a + c) && (t < tt);
      e_cas  = (t >= a + c + s) && (t < a + c + s + w);
      e_we   = wr && (t >= a + c) && (t < a + c + s + w);
      e_done = (t == tt);
      e_busy = (t <= tt);
      e_addr = e_sel ? CA : RA;
      exp = {e_ras, e_sel, e_cas, e_we, e_done, e_busy, 1'b0, e_addr};
      act = {row_strobe, addr_sel_col, col_strobe, wr_en, done, busy, config_error, addr_out};
      check1(act == exp, tag, $sformatf("cycle %0d {ras,sel,cas,we,done,busy,err,addr}", t),
             64'(act), 64'(exp));
   endtask

   // Runs one access; disturb changes inputs and pulses an illegal request mid-access.
   task automatic run_access(input logic [15:0] cfg, input bit wr, input bit disturb,
                             input string tag);
      int a, s, c, h, w, tt;
      a = int'(cfg[1:0]); s = int'(cfg[3:2]); c = int'(cfg[5:4]);
      h = int'(cfg[8:6]); w = int'(cfg[15:11]);
      tt = a + c + s + w + h;
      @(negedge clk);
      cfg_word = cfg; req_write = wr; row_addr = RA; col_addr = CA; req = 1'b1;
      for (int t = 0; t <= tt + 1; t++) begin
         @(negedge clk);
         cmp_cycle(t, a, c, s, w, h, wr, tag);
         req = 1'b0;
         if (disturb && t == 1) begin
            cfg_word = 16'h0000; req_write = ~wr;
            row_addr = 12'hFFF; col_addr = 12'h000; req = 1'b1;
         end
      end
   endtask

   task automatic run_bad(input logic [15:0] cfg, input string what);
      @(negedge clk);
      cfg_word = cfg; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check1(config_error && !busy && !row_strobe, "R2", {what, " refused"},
             64'({config_error, busy, row_strobe}), 64'(3'b100));
      @(negedge clk);
      check1(!config_error && !busy, "R2", {what, " error one cycle"},
             64'({config_error, busy}), 64'(2'b00));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R10: outputs low during reset
      repeat (3) @(negedge clk);
      check1({row_strobe, col_strobe, addr_sel_col, wr_en, done, busy, config_error} == '0,
             "R10", "reset outputs",
             64'({row_strobe, col_strobe, addr_sel_col, wr_en, done, busy, config_error}), 64'(0));
      rst_n = 1'b1;

      // Vector table: R1 R3 R4 R5 R6 R7 R8 (spare bits 10:9 set in some rows: R1)
      foreach (VECS[i]) begin
         run_access(VECS[i][15:0], VECS[i][16], 1'b0, $sformatf("R1/R3-R8 vec%0d", i));
      end

      // R9: inputs changed and a request pulsed during an access
      run_access(mk(2, 1, 3, 2, 4), 1'b1, 1'b1, "R9 disturbed write");
      run_access(mk(1, 2, 1, 1, 3), 1'b0, 1'b1, "R9 disturbed read");

      // R2: every illegal form
      run_bad(mk(0, 1, 1, 1, 1), "row setup zero");
      run_bad(mk(1, 0, 1, 1, 1), "column setup zero");
      run_bad(mk(1, 1, 0, 1, 1), "column output zero");
      run_bad(mk(1, 1, 1, 0, 1), "row hold zero");
      run_bad(mk(1, 1, 1, 1, 0), "column width zero");
      run_bad(mk(3, 1, 2, 1, 1), "column output below row setup");

      // R8: request held through done; next access starts at T+2
      begin
         int tt;
         tt = 5;
         @(negedge clk);
         cfg_word = mk(1, 1, 1, 1, 1); req_write = 1'b0; row_addr = RA; col_addr = CA; req = 1'b1;
         for (int t = 0; t <= tt + 2; t++) begin
            @(negedge clk);
            if (t <= tt + 1) cmp_cycle(t, 1, 1, 1, 1, 1, 1'b0, "R8 held request");
            else begin
               check1(busy && !row_strobe && !done, "R8", "restart at T+2",
                      64'({busy, row_strobe, done}), 64'(3'b100));
               req = 1'b0;
            end
         end
         repeat (tt + 2) @(negedge clk);
         check1(!busy, "R8", "second access ended", 64'(busy), 64'(0));
      end

      // R10: reset in the middle of an access
      @(negedge clk);
      cfg_word = mk(2, 2, 2, 3, 9); req_write = 1'b1; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check1({row_strobe, col_strobe, addr_sel_col, wr_en, done, busy} == '0,
             "R10", "mid-access reset",
             64'({row_strobe, col_strobe, addr_sel_col, wr_en, done, busy}), 64'(0));
      @(negedge clk);
      rst_n = 1'b1;
      run_access(mk(1, 1, 1, 1, 1), 1'b1, 1'b0, "R10 after reset");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule